// File: doc/BRIEF.md
# Malformed TLP Detector

This block sits in the receive path of a PCI Express transaction layer. It judges whether each arriving transaction layer packet is malformed. Header extraction has already happened upstream. On one cycle the block receives the parsed header fields, the number of dwords that actually arrived on the link and the programmed maximum payload size code. These are presented together with an `in_valid` strobe.

One cycle later the block raises a fatal-error pulse and a drop pulse together if any rule is broken. The rules are:
- the header fields are checked against the received length;
- a digest bit is checked against a digest dword that must actually be present;
- a byte-enable rule applies to requests;
- a request may not run past a 4 KB page;
- a set of control messages must travel on traffic class 0.

The upstream packet buffer uses the drop pulse to discard the packet. Error reporting logic counts the fatal pulse as an uncorrectable fatal error. ECRC arithmetic and the building of error messages belong to other blocks.

Top module: `mtlp_detect`

## Requirements
- R1: While reset is held, and in every cycle that follows a cycle with `in_valid` low, both `err_fatal` and `drop` are 0.
- R2: Only these format/type pairs are defined. A `fmt` of 4 to 7 is never defined. With `fmt` below 4, the defined pairs are:
  - `typ` 0 with any `fmt`;
  - `typ` 1 with `fmt` 0 or 1;
  - `typ` 2, 4, 5, 10 or 11 with `fmt` 0 or 2;
  - `typ` 16 to 23 with `fmt` 1 or 3.

  Every other pair is malformed.
- R3: For a defined packet, the expected count is header dwords (3 when `fmt[0]`=0, 4 when 1) plus payload dwords plus `td`. Payload dwords are the decoded length when `fmt[1]`=1, else 0. The length field decodes 0 as 1024. Any other `rcv_dw` is malformed. An I/O (`typ` 2) or configuration (`typ` 4/5) packet whose length field is not 1 is also malformed.
- R4: A packet that carries exactly one dword more than header plus payload while `td`=0 is malformed. So is one that carries exactly header plus payload while `td`=1.
- R5: A packet with `fmt[1]`=1 is malformed if its payload in bytes exceeds 128 shifted left by `mps`. Codes 6 and 7 are treated as 5. A packet without data is never judged by this rule.
- R6: A memory request (`typ` 0 or 1) is malformed when `addr_off` plus the decoded length exceeds 1024 dwords. `addr_off` is the dword offset within its 4 KB page.
- R7: Requests (`typ` 0, 1, 2, 4, 5) must follow the byte-enable rules. With a length field of 1, `lbe` must be 0. Otherwise `fbe` and `lbe` must both be nonzero. Completions and messages are exempt.
- R8: A message (`typ` 16 to 23) with `tc` not 0 is malformed when `msg_code` is one of: 0x00, 0x14, 0x18, 0x19, 0x1B, 0x20 to 0x27, 0x30, 0x31, 0x33 or 0x50. Other codes may use any traffic class.
- R9: When `in_valid` is high, `err_fatal` and `drop` in the next cycle are both 1 if the packet is malformed and both 0 if it is not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Header fields are valid this cycle |
| fmt | input | 3 | Format field |
| typ | input | 5 | Type field |
| len | input | 10 | Length field in dwords, 0 means 1024 |
| td | input | 1 | Digest-present bit of the header |
| tc | input | 3 | Traffic class |
| fbe | input | 4 | First dword byte enables |
| lbe | input | 4 | Last dword byte enables |
| addr_off | input | 10 | Dword offset of the address within its 4 KB page |
| msg_code | input | 8 | Message code byte (messages only) |
| rcv_dw | input | 11 | Dwords actually received, header and digest included |
| mps | input | 3 | Maximum payload size code |
| err_fatal | output | 1 | Fatal malformed-packet error pulse |
| drop | output | 1 | Discard the packet pulse |

## Verification
The digest rule and the length-consistency rule read the same received count. A count one dword away from the expected value can therefore be judged by either rule. The bench walks `rcv_dw` from two below to two above the expected count, with both values of `td`, for 3- and 4-dword headers at several lengths. It requires a malformed verdict at every offset except the single consistent one. The maximum-payload and 4 KB rules can also fire on the same packet. A 1024-dword write at a nonzero offset under a small size code breaks both, and the bench checks that the single combined pulse still appears.

// File: rtl/mtlp_pkg.sv
package mtlp_pkg;
  localparam int LEN_W       = 10;
  localparam int DW_W        = LEN_W + 1;
  localparam int PAGE_W      = 10;
  localparam int MPS_W       = 3;
  localparam int MPS_TOP     = 5;
  localparam int MPS_BASE_DW = 32;
  localparam int TC_W        = 3;
  localparam int BE_W        = 4;
  localparam int CODE_W      = 8;

  typedef enum logic [2:0] {
    K_BAD, K_MEM, K_MEMLK, K_IO, K_CFG, K_MSG, K_CPL
  } kind_e;

  // Length field to dword count, zero standing for the largest size.
  function automatic logic [DW_W-1:0] len_to_dw(input logic [LEN_W-1:0] l);
    return (l == '0) ? {1'b1, {LEN_W{1'b0}}} : {1'b0, l};
  endfunction

  // Payload limit in dwords for a size code, saturating at MPS_TOP.
  function automatic logic [DW_W-1:0] mps_limit_dw(input logic [MPS_W-1:0] code);
    logic [MPS_W-1:0] c;
    c = (code > MPS_W'(MPS_TOP)) ? MPS_W'(MPS_TOP) : code;
    return DW_W'(MPS_BASE_DW) << c;
  endfunction

  // Control messages restricted to traffic class 0.
  function automatic logic msg_needs_tc0(input logic [CODE_W-1:0] code);
    case (code)
      8'h00, 8'h14, 8'h18, 8'h19, 8'h1B,
      8'h30, 8'h31, 8'h33, 8'h50: return 1'b1;
      default: return (code[7:3] == 5'b00100);
    endcase
  endfunction
endpackage

// File: rtl/mtlp_decode.sv
module mtlp_decode
  import mtlp_pkg::*;
(
  input  logic [2:0] fmt,
  input  logic [4:0] typ,
  output kind_e      kind,
  output logic       hdr4,
  output logic       has_data
);
  always_comb begin
    hdr4     = fmt[0];
    has_data = fmt[1];
    kind     = K_BAD;
    if (!fmt[2]) begin
      if (typ == 5'b00000)                      kind = K_MEM;
      else if (typ == 5'b00001 && !fmt[1])      kind = K_MEMLK;
      else if (typ == 5'b00010 && !fmt[0])      kind = K_IO;
      else if (typ[4:1] == 4'b0010 && !fmt[0])  kind = K_CFG;
      else if (typ[4:3] == 2'b10 && fmt[0])     kind = K_MSG;
      else if (typ[4:1] == 4'b0101 && !fmt[0])  kind = K_CPL;
    end
  end
endmodule

// File: rtl/mtlp_size_chk.sv
module mtlp_size_chk
  import mtlp_pkg::*;
(
  input  kind_e             kind,
  input  logic              hdr4,
  input  logic              has_data,
  input  logic              td,
  input  logic [LEN_W-1:0]  len,
  input  logic [DW_W-1:0]   rcv_dw,
  input  logic [MPS_W-1:0]  mps,
  input  logic [PAGE_W-1:0] addr_off,
  output logic              f_len,
  output logic              f_dig,
  output logic              f_mps,
  output logic              f_4k
);
  localparam logic [DW_W-1:0] PAGE_DW = DW_W'(1) << PAGE_W;

  logic [DW_W-1:0] len_dw, pay_dw, base_dw, end_dw;
  logic            known, single_dw, mem_req, rcv_mismatch;

  always_comb begin
    len_dw       = len_to_dw(len);
    pay_dw       = has_data ? len_dw : '0;
    base_dw      = (hdr4 ? DW_W'(4) : DW_W'(3)) + pay_dw;
    end_dw       = {1'b0, addr_off} + len_dw;
    known        = (kind != K_BAD);
    single_dw    = (kind == K_IO) || (kind == K_CFG);
    mem_req      = (kind == K_MEM) || (kind == K_MEMLK);
    rcv_mismatch = (rcv_dw != base_dw + DW_W'(td));
    f_dig = known && (td ? (rcv_dw == base_dw) : (rcv_dw == base_dw + DW_W'(1)));
    f_len = known && ((rcv_mismatch && !f_dig) || (single_dw && len != LEN_W'(1)));
    f_mps = known && has_data && (pay_dw > mps_limit_dw(mps));
    f_4k  = mem_req && (end_dw > PAGE_DW);
  end
endmodule

// File: rtl/mtlp_rule_chk.sv
module mtlp_rule_chk
  import mtlp_pkg::*;
(
  input  kind_e             kind,
  input  logic [LEN_W-1:0]  len,
  input  logic [BE_W-1:0]   fbe,
  input  logic [BE_W-1:0]   lbe,
  input  logic [TC_W-1:0]   tc,
  input  logic [CODE_W-1:0] msg_code,
  output logic              f_be,
  output logic              f_tc
);
  logic is_req, one_dw;

  always_comb begin
    is_req = (kind == K_MEM) || (kind == K_MEMLK) || (kind == K_IO) || (kind == K_CFG);
    one_dw = (len == LEN_W'(1));
    f_be   = is_req && (one_dw ? (lbe != '0) : ((fbe == '0) || (lbe == '0)));
    f_tc   = (kind == K_MSG) && msg_needs_tc0(msg_code) && (tc != '0);
  end
endmodule

// File: rtl/mtlp_detect.sv
module mtlp_detect
  import mtlp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        fmt,
  input  logic [4:0]        typ,
  input  logic [LEN_W-1:0]  len,
  input  logic              td,
  input  logic [TC_W-1:0]   tc,
  input  logic [BE_W-1:0]   fbe,
  input  logic [BE_W-1:0]   lbe,
  input  logic [PAGE_W-1:0] addr_off,
  input  logic [CODE_W-1:0] msg_code,
  input  logic [DW_W-1:0]   rcv_dw,
  input  logic [MPS_W-1:0]  mps,
  output logic              err_fatal,
  output logic              drop
);
  kind_e kind;
  logic  hdr4, has_data;
  logic  f_fmt, f_len, f_dig, f_mps, f_4k, f_be, f_tc, bad;
  logic  mal_q;

  mtlp_decode u_dec (.fmt(fmt), .typ(typ), .kind(kind), .hdr4(hdr4), .has_data(has_data));

  mtlp_size_chk u_size (
    .kind(kind), .hdr4(hdr4), .has_data(has_data), .td(td), .len(len),
    .rcv_dw(rcv_dw), .mps(mps), .addr_off(addr_off),
    .f_len(f_len), .f_dig(f_dig), .f_mps(f_mps), .f_4k(f_4k)
  );

  mtlp_rule_chk u_rule (
    .kind(kind), .len(len), .fbe(fbe), .lbe(lbe), .tc(tc), .msg_code(msg_code),
    .f_be(f_be), .f_tc(f_tc)
  );

  assign f_fmt = (kind == K_BAD);
  assign bad   = f_fmt | f_len | f_dig | f_mps | f_4k | f_be | f_tc;

  always_ff @(posedge clk) begin
    if (!rst_n) mal_q <= 1'b0;
    else        mal_q <= in_valid & bad;
  end

  assign err_fatal = mal_q;
  assign drop      = mal_q;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!err_fatal && !drop));
  assert_undef_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && f_fmt) |=> (err_fatal && drop));
  assert_len_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && f_len) |=> drop);
  assert_digest_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && f_dig) |=> drop);
  assert_mps_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && f_mps) |=> err_fatal);
  assert_page_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && f_4k) |=> err_fatal);
  assert_be_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && f_be) |=> drop);
  assert_tc_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && f_tc) |=> drop);
  assert_clean_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !bad) |=> (!err_fatal && !drop));
endmodule

// File: tb/test_mtlp_detect.sv
module test_mtlp_detect;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [2:0] b_fmt = '0;
  logic [4:0] b_typ = '0;
  logic [9:0] b_len = 10'd1;
  logic       b_td = 1'b0;
  logic [2:0] b_tc = '0;
  logic [3:0] b_fbe = 4'hF;
  logic [3:0] b_lbe = '0;
  logic [9:0] b_off = '0;
  logic [7:0] b_code = 8'h7F;
  logic [10:0] b_rcv = 11'd4;
  logic [2:0] b_mps = 3'd5;
  logic       err_fatal, drop;
  int nvec = 0;
  int nbad = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  mtlp_detect i_mtlp_detect (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt(b_fmt), .typ(b_typ),
    .len(b_len), .td(b_td), .tc(b_tc), .fbe(b_fbe), .lbe(b_lbe),
    .addr_off(b_off), .msg_code(b_code), .rcv_dw(b_rcv), .mps(b_mps),
    .err_fatal(err_fatal), .drop(drop)
  );

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        nbad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
      end
    end
  end

  function automatic int hdr_words();
    return b_fmt[0] ? 4 : 3;
  endfunction

  function automatic int len_words();
    return (b_len == 0) ? 1024 : int'(b_len);
  endfunction

  function automatic int pay_words();
    return (b_fmt >= 2 && b_fmt <= 3) ? len_words() : 0;
  endfunction

  task automatic set_rcv_ok();
    b_rcv = 11'(hdr_words() + pay_words() + int'(b_td));
  endtask

  task automatic fix_be();
    b_fbe = 4'hF;
    b_lbe = (b_len == 1) ? 4'h0 : 4'hF;
  endtask

  function automatic bit restricted_code(int c);
    return c == 0 || c == 'h14 || c == 'h18 || c == 'h19 || c == 'h1B ||
           (c >= 'h20 && c <= 'h27) || c == 'h30 || c == 'h31 || c == 'h33 || c == 'h50;
  endfunction

  function automatic bit model();
    int f, t, cls, dw, pay, lim, m;
    f = int'(b_fmt); t = int'(b_typ); cls = 0;
    if (f < 4) begin
      if (t == 0) cls = 1;
      else if (t == 1 && f < 2) cls = 2;
      else if (t == 2 && (f == 0 || f == 2)) cls = 3;
      else if ((t == 4 || t == 5) && (f == 0 || f == 2)) cls = 4;
      else if (t >= 16 && t <= 23 && (f == 1 || f == 3)) cls = 5;
      else if ((t == 10 || t == 11) && (f == 0 || f == 2)) cls = 6;
    end
    if (cls == 0) return 1;
    dw = len_words();
    pay = pay_words();
    if (int'(b_rcv) != hdr_words() + pay + int'(b_td)) return 1;
    if ((cls == 3 || cls == 4) && b_len != 1) return 1;
    m = (b_mps > 5) ? 5 : int'(b_mps);
    lim = 128 * (2 ** m);
    if (pay * 4 > lim) return 1;
    if ((cls == 1 || cls == 2) && (int'(b_off) * 4 + dw * 4 > 4096)) return 1;
    if (cls >= 1 && cls <= 4) begin
      if (dw == 1) begin
        if (b_lbe != 0) return 1;
      end else if (b_fbe == 0 || b_lbe == 0) return 1;
    end
    if (cls == 5 && b_tc != 0 && restricted_code(int'(b_code))) return 1;
    return 0;
  endfunction

  task automatic fire(input string req);
    bit exp;
    exp = model();
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    nvec++;
    if (err_fatal !== exp || drop !== exp) begin
      nbad++;
      $display("FAIL %s fmt=%0d typ=%0d len=%0d td=%0d rcv=%0d: actual err=%b drop=%b expected %b",
               req, b_fmt, b_typ, b_len, b_td, b_rcv, err_fatal, drop, exp);
    end
  endtask

  task automatic idle_check();
    @(negedge clk);
    nvec++;
    if (err_fatal !== 1'b0 || drop !== 1'b0) begin
      nbad++;
      $display("FAIL R1 idle: actual err=%b drop=%b expected 0 0", err_fatal, drop);
    end
  endtask

  task automatic mwr_defaults();
    b_fmt = 3'd2; b_typ = 5'd0; b_len = 10'd1; b_td = 1'b0; b_tc = '0;
    b_off = '0; b_code = 8'h7F; b_mps = 3'd5;
    fix_be(); set_rcv_ok();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    nvec++;
    if (err_fatal !== 1'b0 || drop !== 1'b0) begin
      nbad++;
      $display("FAIL R1 reset: actual err=%b drop=%b expected 0 0", err_fatal, drop);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R2: every format/type pair with an otherwise consistent packet
    mwr_defaults();
    for (int f = 0; f < 8; f++) begin
      for (int t = 0; t < 32; t++) begin
        b_fmt = 3'(f); b_typ = 5'(t); b_len = 10'd1; b_td = 1'b0;
        fix_be(); set_rcv_ok();
        fire("R2");
      end
    end
    idle_check();

    // R3 / R4: received count around the expected value, both digest states
    foreach (b_fmt[i]) ;
    for (int h = 2; h < 4; h++) begin
      for (int li = 0; li < 4; li++) begin
        for (int d = 0; d < 2; d++) begin
          for (int k = -2; k <= 2; k++) begin
            mwr_defaults();
            b_fmt = 3'(h);
            b_len = (li == 0) ? 10'd1 : (li == 1) ? 10'd2 : (li == 2) ? 10'd5 : 10'd0;
            b_td = d[0];
            fix_be(); set_rcv_ok();
            b_rcv = 11'(int'(b_rcv) + k);
            fire((k == 1 && d == 0) || (k == -1 && d == 1) ? "R4" : "R3");
          end
        end
      end
    end
    // R3: I/O and configuration packets must have a length of one
    for (int t = 2; t < 6; t++) begin
      for (int l = 1; l < 4; l++) begin
        mwr_defaults();
        b_typ = 5'(t); b_len = 10'(l);
        fix_be(); set_rcv_ok();
        fire("R3");
      end
    end
    idle_check();

    // R5: payload limit for every size code
    for (int m = 0; m < 8; m++) begin
      for (int li = 0; li < 8; li++) begin
        mwr_defaults();
        b_mps = 3'(m);
        case (li)
          0: b_len = 10'd1;   1: b_len = 10'd31;  2: b_len = 10'd32;
          3: b_len = 10'd33;  4: b_len = 10'd64;  5: b_len = 10'd256;
          6: b_len = 10'd1023; default: b_len = 10'd0;
        endcase
        fix_be(); set_rcv_ok();
        fire("R5");
      end
    end
    // R5: a read without data is not judged by the payload limit
    mwr_defaults();
    b_fmt = 3'd0; b_len = 10'd512; b_mps = 3'd0; fix_be(); set_rcv_ok();
    fire("R5");
    // R5 with R6 at once: full-size write at a nonzero offset, small code
    mwr_defaults();
    b_len = 10'd0; b_off = 10'd8; b_mps = 3'd1; fix_be(); set_rcv_ok();
    fire("R5");
    idle_check();

    // R6: every page offset for reads of several lengths
    for (int li = 0; li < 3; li++) begin
      for (int o = 0; o < 1024; o++) begin
        mwr_defaults();
        b_fmt = 3'd0;
        b_len = (li == 0) ? 10'd1 : (li == 1) ? 10'd2 : 10'd16;
        b_off = 10'(o);
        fix_be(); set_rcv_ok();
        fire("R6");
      end
    end
    // R6: locked read crossing, 64-bit write crossing
    mwr_defaults(); b_fmt = 3'd1; b_typ = 5'd1; b_len = 10'd4; b_off = 10'd1022;
    fix_be(); set_rcv_ok(); fire("R6");
    mwr_defaults(); b_fmt = 3'd3; b_len = 10'd2; b_off = 10'd1023;
    fix_be(); set_rcv_ok(); fire("R6");
    idle_check();

    // R7: all byte-enable pairs, single and multi dword reads
    for (int li = 0; li < 2; li++) begin
      for (int fb = 0; fb < 16; fb++) begin
        for (int lb = 0; lb < 16; lb++) begin
          mwr_defaults();
          b_fmt = 3'd0; b_len = (li == 0) ? 10'd1 : 10'd3;
          b_fbe = 4'(fb); b_lbe = 4'(lb);
          set_rcv_ok();
          fire("R7");
        end
      end
    end
    // R7: completions are exempt from byte-enable rules
    mwr_defaults(); b_fmt = 3'd0; b_typ = 5'd10; b_len = 10'd1;
    b_fbe = 4'h0; b_lbe = 4'hF; set_rcv_ok(); fire("R7");
    idle_check();

    // R8: every message code on every traffic class
    for (int c = 0; c < 256; c++) begin
      for (int t = 0; t < 8; t++) begin
        mwr_defaults();
        b_fmt = 3'd1; b_typ = 5'(16 + (c % 8)); b_code = 8'(c); b_tc = 3'(t);
        set_rcv_ok();
        fire("R8");
      end
    end
    idle_check();

    // R9: back-to-back good and bad packets
    for (int n = 0; n < 16; n++) begin
      mwr_defaults();
      if (n % 2 == 1) b_tc = 3'd1;
      b_fmt = 3'd3; b_typ = 5'd16; b_code = (n % 4 < 2) ? 8'h50 : 8'h7E;
      set_rcv_ok();
      fire("R9");
    end
    idle_check();

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule